// File: doc/BRIEF.md
# Paged SRAM Address Latch Controller

This block gives a host a byte-wide window onto 1 MB of external static RAM built from two 512 KB chips. The host offers a 20-bit linear byte address together with a read or a write command. The block does not drive the memory address pins itself. It shares one 8-bit data bus and a 3-bit decoded select with other peripherals. It loads three external byte latches in turn: a low, a middle and a high address latch. Chip choice is carried in the top two bits of the high latch, and the block derives the two active-low chip enables from that code.

Every change of the select lines is bracketed by the decoder being switched off, so no other target on the shared bus sees a stray strobe. A write holds the data on the bus with the chip enabled, then pulses write enable low for a fixed number of cycles. A read turns the bus around to input before any chip is enabled, then captures the data after a fixed access count. After either kind of access, the high latch is rewritten with the "no chip" code, the select returns to the idle target, and a one-cycle completion pulse is raised.

Top module: `sram_pager`

## Requirements
- R1: After reset and between commands: select = 3, decoder enable high, bus driven as output, write enable high, both chip enables high (`ce_n` = 2'b11), `cmd_ready` high.
- R2: An accepted command loads the latches in this order: select 4 with address bits 7:0, then select 5 with bits 15:8, then select 6 with {chip code in bits 7:6, 3'b000, address bits 18:16}. Each load is three cycles: decoder off with the old select, new select with the decoder off and the byte on the bus, then decoder on.
- R3: Address bit 19 = 0 gives chip code 2'b10 and bit 19 = 1 gives 2'b01. While a chip is enabled, `ce_n` equals that code, so `ce_n[0]` low enables the lower chip.
- R4: The select lines change only while the decoder is disabled, and the decoder was also disabled in the previous cycle.
- R5: In a write, the write data and the chip enable are present one cycle before write enable falls. Write enable stays low for WE_CYCLES cycles. Data and enable are held one more cycle after write enable rises.
- R6: In a read, the bus turns to input one cycle before the chip is enabled. The chip stays enabled for ACCESS_CYCLES cycles and `rd_data` takes `bus_in` from the last of them. The chip is disabled one cycle before the bus turns back to output.
- R7: After every access, the high latch is reloaded at select 6 with 2'b11 in bits 7:6 and the same bits 2:0.
- R8: The command ends with select 3 and the decoder on, `done` high for exactly that one cycle, and `cmd_ready` high in the cycle after.
- R9: A command presented while `cmd_ready` is low is ignored and leaves the running sequence unchanged.
- R10: Both chip enables are never low together, and write enable is never low while the bus is turned to input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 20 | Linear byte address |
| cmd_wdata | input | 8 | Write byte |
| cmd_ready | output | 1 | Idle, accepts a command this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| bus_sel | output | 3 | Decoder select lines |
| dec_en | output | 1 | Decoder output enable |
| bus_out | output | 8 | Data driven onto the shared bus |
| bus_oe | output | 1 | 1 = bus driven by this block |
| bus_in | input | 8 | Data read from the shared bus |
| we_n | output | 1 | Memory write enable, active low |
| ce_n | output | 2 | Chip enables, active low, bit 0 = lower chip |

## Verification
The bench targets the 0x7FFFF/0x80000 chip boundary and the two ends of the address space. It writes the same in-chip offset in both chips, so a wrong chip code from bit 19 shows up as one byte overwriting the other on read-back. A reference model compares every output every cycle. A select that moves with the decoder on, a write enable pulse one cycle short, or a capture before the chip is enabled each appear as a mismatch on a named cycle. A command raised in the middle of a sequence must not restart or corrupt it. A design that skipped the deselect reload would leave the bench's modelled high latch holding a chip code after the access.

// File: rtl/sram_pager_pkg.sv
package sram_pager_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LAT_OFF,
    ST_LAT_SEL,
    ST_LAT_ON,
    ST_PARK,
    ST_WR_SETUP,
    ST_WE_LOW,
    ST_WE_HOLD,
    ST_RD_TURN,
    ST_RD_WAIT,
    ST_RD_END,
    ST_RLD_DATA,
    ST_RLD_ON,
    ST_RLD_OFF,
    ST_RET_SEL,
    ST_RET_ON
  } pager_state_e;

  localparam logic [2:0] SEL_IDLE = 3'd3;
  localparam logic [2:0] SEL_LOW  = 3'd4;
  localparam logic [2:0] SEL_HIGH = 3'd6;

  localparam logic [1:0] CODE_CHIP0 = 2'b10;
  localparam logic [1:0] CODE_CHIP1 = 2'b01;
  localparam logic [1:0] CODE_NONE  = 2'b11;

  typedef struct packed {
    logic [2:0] sel;
    logic       dec_en;
    logic       oe;
    logic [7:0] dout;
    logic       we_n;
    logic [1:0] ce_n;
    logic       done;
    logic       ready;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_RESET = '{sel: SEL_IDLE, dec_en: 1'b1, oe: 1'b1,
                                     dout: 8'h00, we_n: 1'b1, ce_n: CODE_NONE,
                                     done: 1'b0, ready: 1'b1};

endpackage

// File: rtl/sram_pager_addr_map.sv
module sram_pager_addr_map
  import sram_pager_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        byte_low,
  output logic [7:0]        byte_mid,
  output logic [7:0]        byte_high_sel,
  output logic [7:0]        byte_high_off,
  output logic [1:0]        chip_code
);
  localparam int CHIP_AW = ADDR_W - 1;
  localparam int HI_BITS = CHIP_AW - 16;
  localparam int PAD_W   = 6 - HI_BITS;

  logic [HI_BITS-1:0] hi_part;

  assign hi_part       = addr[CHIP_AW-1:16];
  assign chip_code     = addr[ADDR_W-1] ? CODE_CHIP1 : CODE_CHIP0;
  assign byte_low      = addr[7:0];
  assign byte_mid      = addr[15:8];
  assign byte_high_sel = {chip_code, {PAD_W{1'b0}}, hi_part};
  assign byte_high_off = {CODE_NONE, {PAD_W{1'b0}}, hi_part};
endmodule

// File: rtl/sram_pager_timer.sv
module sram_pager_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_pager.sv
module sram_pager
  import sram_pager_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int WE_CYCLES     = 2,
  parameter int ACCESS_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              cmd_ready,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic [2:0]        bus_sel,
  output logic              dec_en,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  input  logic [7:0]        bus_in,
  output logic              we_n,
  output logic [1:0]        ce_n
);
  localparam int MAX_WAIT = (WE_CYCLES > ACCESS_CYCLES) ? WE_CYCLES : ACCESS_CYCLES;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] WE_LOAD  = CNT_W'(WE_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACCESS_CYCLES - 1);
  localparam logic [1:0] LAST_LATCH = 2'd2;

  pager_state_e      state, nxt_state;
  logic [1:0]        lat_idx, nxt_idx;
  logic              is_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  bus_ctl_t          ctl_q, nxt_ctl;
  logic [7:0]        rd_q;

  logic [7:0] b_low, b_mid, b_hsel, b_hoff;
  logic [1:0] code;
  logic       tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic       accept;

  sram_pager_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr          (addr_q),
    .byte_low      (b_low),
    .byte_mid      (b_mid),
    .byte_high_sel (b_hsel),
    .byte_high_off (b_hoff),
    .chip_code     (code)
  );

  sram_pager_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign accept = (state == ST_IDLE) && cmd_valid;

  // sequencing
  always_comb begin
    nxt_state = state;
    nxt_idx   = lat_idx;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE:     if (cmd_valid) begin
                     nxt_state = ST_LAT_OFF;
                     nxt_idx   = 2'd0;
                   end
      ST_LAT_OFF:  nxt_state = ST_LAT_SEL;
      ST_LAT_SEL:  nxt_state = ST_LAT_ON;
      ST_LAT_ON:   if (lat_idx == LAST_LATCH) nxt_state = ST_PARK;
                   else begin
                     nxt_state = ST_LAT_OFF;
                     nxt_idx   = lat_idx + 2'd1;
                   end
      ST_PARK:     nxt_state = is_wr ? ST_WR_SETUP : ST_RD_TURN;
      ST_WR_SETUP: begin
                     nxt_state = ST_WE_LOW;
                     tmr_load  = 1'b1;
                     tmr_val   = WE_LOAD;
                   end
      ST_WE_LOW:   if (tmr_zero) nxt_state = ST_WE_HOLD;
      ST_WE_HOLD:  nxt_state = ST_RLD_DATA;
      ST_RD_TURN:  begin
                     nxt_state = ST_RD_WAIT;
                     tmr_load  = 1'b1;
                     tmr_val   = ACC_LOAD;
                   end
      ST_RD_WAIT:  if (tmr_zero) nxt_state = ST_RD_END;
      ST_RD_END:   nxt_state = ST_RLD_DATA;
      ST_RLD_DATA: nxt_state = ST_RLD_ON;
      ST_RLD_ON:   nxt_state = ST_RLD_OFF;
      ST_RLD_OFF:  nxt_state = ST_RET_SEL;
      ST_RET_SEL:  nxt_state = ST_RET_ON;
      ST_RET_ON:   nxt_state = ST_IDLE;
      default:     nxt_state = ST_IDLE;
    endcase
  end

  // output decode for the state about to be entered
  always_comb begin
    nxt_ctl        = ctl_q;
    nxt_ctl.dec_en = 1'b0;
    nxt_ctl.oe     = 1'b1;
    nxt_ctl.we_n   = 1'b1;
    nxt_ctl.ce_n   = CODE_NONE;
    nxt_ctl.done   = 1'b0;
    nxt_ctl.ready  = 1'b0;
    unique case (nxt_state)
      ST_IDLE:     begin nxt_ctl.dec_en = 1'b1; nxt_ctl.ready = 1'b1; end
      ST_LAT_SEL:  begin
                     nxt_ctl.sel = 3'(SEL_LOW + {1'b0, nxt_idx});
                     unique case (nxt_idx)
                       2'd0:    nxt_ctl.dout = b_low;
                       2'd1:    nxt_ctl.dout = b_mid;
                       default: nxt_ctl.dout = b_hsel;
                     endcase
                   end
      ST_LAT_ON,
      ST_RLD_ON:   nxt_ctl.dec_en = 1'b1;
      ST_WR_SETUP: begin nxt_ctl.dout = wdata_q; nxt_ctl.ce_n = code; end
      ST_WE_LOW:   begin nxt_ctl.we_n = 1'b0; nxt_ctl.ce_n = code; end
      ST_WE_HOLD:  nxt_ctl.ce_n = code;
      ST_RD_TURN,
      ST_RD_END:   nxt_ctl.oe = 1'b0;
      ST_RD_WAIT:  begin nxt_ctl.oe = 1'b0; nxt_ctl.ce_n = code; end
      ST_RLD_DATA: begin nxt_ctl.sel = SEL_HIGH; nxt_ctl.dout = b_hoff; end
      ST_RET_SEL:  nxt_ctl.sel = SEL_IDLE;
      ST_RET_ON:   begin nxt_ctl.dec_en = 1'b1; nxt_ctl.done = 1'b1; end
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      lat_idx <= 2'd0;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= 8'h00;
      ctl_q   <= CTL_RESET;
      rd_q    <= 8'h00;
    end else begin
      state   <= nxt_state;
      lat_idx <= nxt_idx;
      ctl_q   <= nxt_ctl;
      if (accept) begin
        is_wr   <= cmd_write;
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
      end
      if (state == ST_RD_WAIT && tmr_zero) rd_q <= bus_in;
    end
  end

  assign cmd_ready = ctl_q.ready;
  assign done      = ctl_q.done;
  assign rd_data   = rd_q;
  assign bus_sel   = ctl_q.sel;
  assign dec_en    = ctl_q.dec_en;
  assign bus_out   = ctl_q.dout;
  assign bus_oe    = ctl_q.oe;
  assign we_n      = ctl_q.we_n;
  assign ce_n      = ctl_q.ce_n;
endmodule

// File: rtl/sram_pager_chk.sv
module sram_pager_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_ready,
  input logic       done,
  input logic [2:0] bus_sel,
  input logic       dec_en,
  input logic       bus_oe,
  input logic       we_n,
  input logic [1:0] ce_n
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
    cmd_ready |-> (ce_n == 2'b11 && we_n && bus_oe && bus_sel == 3'd3 && dec_en)); // R1
  AST_SEL_GUARDED: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_sel != $past(bus_sel)) |-> (!dec_en && !$past(dec_en))); // R4
  AST_WE_FRAMED: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(we_n) |-> ($past(ce_n) != 2'b11 && $stable(ce_n))); // R5
  AST_TURN_FIRST: assert property (@(posedge clk) disable iff (rst || !armed)
    (ce_n != 2'b11 && !bus_oe) |-> !$past(bus_oe)); // R6
  AST_DONE_HOME: assert property (@(posedge clk) disable iff (rst || !armed)
    done |-> (bus_sel == 3'd3 && dec_en)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst || !armed)
    done |=> (!done && cmd_ready)); // R8
  AST_ONE_CHIP: assert property (@(posedge clk) disable iff (rst || !armed)
    (ce_n != 2'b00) && (we_n || bus_oe)); // R10
endmodule

bind sram_pager sram_pager_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .done      (done),
  .bus_sel   (bus_sel),
  .dec_en    (dec_en),
  .bus_oe    (bus_oe),
  .we_n      (we_n),
  .ce_n      (ce_n)
);

// File: tb/tb_sram_pager.sv
module tb_sram_pager;
  localparam int WE_C  = 2;
  localparam int ACC_C = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [19:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready, done;
  logic [7:0]  rd_data, bus_out;
  logic [2:0]  bus_sel;
  logic        dec_en, bus_oe, we_n;
  logic [1:0]  ce_n;
  logic [7:0]  bus_in = 8'h5A;

  sram_pager #(.ADDR_W(20), .WE_CYCLES(WE_C), .ACCESS_CYCLES(ACC_C)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .done(done), .rd_data(rd_data), .bus_sel(bus_sel), .dec_en(dec_en),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .we_n(we_n), .ce_n(ce_n)
  );

  always #10 clk = ~clk;

  typedef struct {
    int sel; int en; int oe; int dout; int we; int ce; int dn; int rdy;
  } step_t;

  step_t q[$];
  step_t cur;
  int    checks = 0, errors = 0, cycles = 0;
  bit    live = 0;
  int    m_dout = 0;
  bit    exp_rd_valid = 0;
  int    exp_rd = 0;
  bit [7:0] gold [int];
  bit [7:0] mem0 [int];
  bit [7:0] mem1 [int];
  bit [7:0] lat_lo = 0, lat_mid = 0, lat_hi = 8'hFF;
  logic     prev_we = 1'b1;

  function automatic bit [7:0] dflt(input int a);
    return 8'(a) ^ 8'hC3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic push(input int s, input int e, input int o, input int d,
                      input int w, input int c, input int dn);
    step_t t;
    t.sel = s; t.en = e; t.oe = o; t.dout = d; t.we = w; t.ce = c; t.dn = dn; t.rdy = 0;
    q.push_back(t);
  endtask

  task automatic build(input bit wr, input bit [19:0] a, input bit [7:0] d);
    int code, hc, hx;
    code = a[19] ? 2'b01 : 2'b10;
    hc = {code[1:0], 3'b000, a[18:16]};
    hx = {2'b11, 3'b000, a[18:16]};
    push(3, 0, 1, m_dout, 1, 3, 0);
    push(4, 0, 1, a[7:0], 1, 3, 0);  push(4, 1, 1, a[7:0], 1, 3, 0);
    push(4, 0, 1, a[7:0], 1, 3, 0);  push(5, 0, 1, a[15:8], 1, 3, 0);
    push(5, 1, 1, a[15:8], 1, 3, 0); push(5, 0, 1, a[15:8], 1, 3, 0);
    push(6, 0, 1, hc, 1, 3, 0); push(6, 1, 1, hc, 1, 3, 0); push(6, 0, 1, hc, 1, 3, 0);
    if (wr) begin
      push(6, 0, 1, d, 1, code, 0);
      for (int i = 0; i < WE_C; i++) push(6, 0, 1, d, 0, code, 0);
      push(6, 0, 1, d, 1, code, 0);
      gold[int'(a)] = d;
    end else begin
      push(6, 0, 0, hc, 1, 3, 0);
      for (int i = 0; i < ACC_C; i++) push(6, 0, 0, hc, 1, code, 0);
      push(6, 0, 0, hc, 1, 3, 0);
      exp_rd = gold.exists(int'(a)) ? int'(gold[int'(a)]) : int'(dflt(int'(a)));
    end
    exp_rd_valid = !wr;
    push(6, 0, 1, hx, 1, 3, 0); push(6, 1, 1, hx, 1, 3, 0); push(6, 0, 1, hx, 1, 3, 0);
    push(3, 0, 1, hx, 1, 3, 0); push(3, 1, 1, hx, 1, 3, 1);
    m_dout = hx;
  endtask

  function automatic step_t idle_step();
    step_t t;
    t.sel = 3; t.en = 1; t.oe = 1; t.dout = m_dout; t.we = 1; t.ce = 3; t.dn = 0; t.rdy = 1;
    return t;
  endfunction

  // monitor, reference model and external-part model, all at negedge
  always @(negedge clk) begin
    int pa;
    cycles++;
    if (live && !rst) begin
      chk(int'(bus_sel) == cur.sel,   "R2 bus_sel", bus_sel, cur.sel);
      chk(int'(bus_out) == cur.dout,  "R2 bus_out", bus_out, cur.dout);
      chk(int'(dec_en) == cur.en,     "R4 dec_en",  dec_en,  cur.en);
      chk(int'(ce_n) == cur.ce,       "R3 ce_n",    ce_n,    cur.ce);
      chk(int'(we_n) == cur.we,       "R5 we_n",    we_n,    cur.we);
      chk(int'(bus_oe) == cur.oe,     "R6 bus_oe",  bus_oe,  cur.oe);
      chk(int'(done) == cur.dn,       "R8 done",    done,    cur.dn);
      chk(int'(cmd_ready) == cur.rdy, "R9 cmd_ready", cmd_ready, cur.rdy);
      chk(ce_n != 2'b00,              "R10 ce_n",   ce_n,    3);
      if (done && exp_rd_valid)
        chk(int'(rd_data) == exp_rd,  "R6 rd_data", rd_data, exp_rd);
      if (done)
        chk(lat_hi[7:6] == 2'b11,     "R7 high latch", lat_hi, {2'b11, 6'h0});
    end
    // external latches and memories
    if (dec_en && bus_oe) begin
      if (bus_sel == 3'd4) lat_lo  = bus_out;
      if (bus_sel == 3'd5) lat_mid = bus_out;
      if (bus_sel == 3'd6) lat_hi  = bus_out;
    end
    pa = {13'd0, lat_hi[2:0], lat_mid, lat_lo};
    if (prev_we == 1'b0 && we_n == 1'b1 && bus_oe) begin
      if (ce_n == 2'b10) mem0[pa] = bus_out;
      if (ce_n == 2'b01) mem1[pa] = bus_out;
    end
    prev_we = we_n;
    if (!bus_oe && ce_n == 2'b10)      bus_in <= mem0.exists(pa) ? mem0[pa] : dflt(pa);
    else if (!bus_oe && ce_n == 2'b01) bus_in <= mem1.exists(pa) ? mem1[pa] : dflt(pa);
    else                               bus_in <= 8'h5A;
    // predict the next cycle
    if (rst) begin
      q.delete();
      m_dout = 0;
      cur = idle_step();
      live = 1;
    end else if (q.size() > 0) begin
      cur = q.pop_front();
    end else if (cur.rdy == 1 && cmd_valid) begin
      build(cmd_write, cmd_addr, cmd_wdata);
      cur = q.pop_front();
    end else begin
      cur = idle_step();
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_cmd(input bit wr, input bit [19:0] a, input bit [7:0] d);
    @(posedge clk); #2;
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #2;
    cmd_valid = 0;
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(bus_sel == 3'd3 && dec_en && bus_oe && we_n && ce_n == 2'b11 && cmd_ready,
        "R1 reset", {bus_sel, dec_en, bus_oe, we_n, ce_n, cmd_ready}, 8'hFF);
    // R2 R3 R5: writes across both chips and the boundaries
    do_cmd(1, 20'h00000, 8'h11);
    do_cmd(1, 20'h7FFFF, 8'h22);
    do_cmd(1, 20'h80000, 8'h33);
    do_cmd(1, 20'hFFFFF, 8'h44);
    do_cmd(1, 20'h12345, 8'hA5);
    do_cmd(1, 20'h92345, 8'h5A);
    // R9: command raised mid-sequence is ignored
    @(posedge clk); #2;
    cmd_valid = 1; cmd_write = 1; cmd_addr = 20'h6789A; cmd_wdata = 8'h77;
    @(negedge clk); while (!cmd_ready) @(negedge clk);
    @(posedge clk); #2;
    cmd_addr = 20'h00000; cmd_wdata = 8'hFF;
    repeat (4) @(posedge clk);
    #2 cmd_valid = 0;
    @(negedge clk); while (!done) @(negedge clk);
    // R6 R3: read back, including an unwritten location
    do_cmd(0, 20'h00000, 8'h00);
    do_cmd(0, 20'h7FFFF, 8'h00);
    do_cmd(0, 20'h80000, 8'h00);
    do_cmd(0, 20'hFFFFF, 8'h00);
    do_cmd(0, 20'h12345, 8'h00);
    do_cmd(0, 20'h92345, 8'h00);
    do_cmd(0, 20'h6789A, 8'h00);
    do_cmd(0, 20'h40001, 8'h00);
    repeat (5) @(negedge clk);
    // R1: idle again after the last command
    chk(cmd_ready && ce_n == 2'b11 && bus_sel == 3'd3, "R1 idle after ops",
        {cmd_ready, ce_n, bus_sel}, {1'b1, 2'b11, 3'd3});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule